// File: doc/BRIEF.md
# Baud-Rate Strobe Generator

This block produces the sampling tick for a serial port: a strobe one clock cycle wide that fires sixteen times per serial bit. It does not derive a second clock. The strobe stays in the bus clock domain. Downstream shift logic uses it as a clock enable, so no clock-domain-crossing logic or Gray-coded pointers are needed between the register side and the serial side.

The 16-bit rate divisor is held in two byte-wide latches, a low byte and a high byte, written through a small register write port. Each latch has its own write strobe. A down-counter reloads from the divisor and lets one bus-clock cycle in every N through as the strobe, where N is the divisor. The strobe rate is therefore the bus clock divided by N.

Writing either latch restarts the counter from the new value. A new rate takes effect at once, without waiting for the old period to run out. A divisor of 1 gives a strobe on every cycle. A divisor of 0 silences the strobe.

Top module: `brg_tick_gen`

## Requirements
- R1: While `rst` is sampled high on a clock edge, both latches clear to zero and `tick` is low in the following cycle; after reset, with the divisor still zero, `tick` stays low.
- R2: A write with `wr_lo` high loads `wr_data` into `div_q[7:0]`, and a write with `wr_hi` high loads it into `div_q[15:8]`; the new value is visible on `div_q` in the cycle after the write edge.
- R3: With a constant nonzero divisor N and no writes, consecutive strobes are exactly N cycles apart; N = 1 gives a strobe on every cycle.
- R4: For a divisor of 2 or more, every strobe is exactly one cycle wide.
- R5: While the divisor reads as 0, `tick` never asserts, from the second cycle after the latch takes the value 0.
- R6: A write on either latch at edge k reloads the counter at edge k+1; the first strobe after it appears in the cycle after edge k+1+N, where N is the divisor after the write, whatever point the old period had reached.
- R7: Writing one latch leaves the other latch unchanged; raising both strobes together loads the same byte into both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the strobe is produced in this domain |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 8 | Byte to be written into the selected latch |
| wr_lo | input | 1 | Write enable of the low divisor byte |
| wr_hi | input | 1 | Write enable of the high divisor byte |
| tick | output | 1 | Single-cycle strobe at sixteen times the bit rate |
| div_q | output | 16 | Current divisor, high byte in bits 15:8, low byte in bits 7:0 |

## Verification
The bench builds the block with its default 8-bit latch width, which gives a 16-bit divisor. With that width the largest divisor, 65535, is measured as a full period, along with the smallest values 1, 2, 3 and 4 and the silent value 0. Random divisors up to 60 are loaded through both latches. Mid-period reloads and a reset during operation show that the strobe restarts from the new value and does not wait for the old count to finish.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 2;
    localparam int DIV_W     = BYTE_W * NUM_BYTES;

    typedef logic [DIV_W-1:0] div_t;

    // What the counter does on the coming edge.
    typedef enum logic [1:0] {
        ACT_HALT   = 2'd0,  // divisor zero: park, no strobe
        ACT_RELOAD = 2'd1,  // divisor just written: restart quietly
        ACT_FIRE   = 2'd2,  // period complete: strobe and restart
        ACT_COUNT  = 2'd3   // count down
    } cnt_act_e;

    typedef struct packed {
        div_t count;
        logic tick;
    } ctr_state_t;

    function automatic cnt_act_e pick_action(input logic div_zero,
                                             input logic reload,
                                             input logic at_end);
        if (div_zero)
            return ACT_HALT;
        else if (reload)
            return ACT_RELOAD;
        else if (at_end)
            return ACT_FIRE;
        else
            return ACT_COUNT;
    endfunction

endpackage

// File: rtl/brg_div_latch.sv
module brg_div_latch #(
    parameter int BYTE_W    = brg_pkg::BYTE_W,
    parameter int NUM_BYTES = brg_pkg::NUM_BYTES,
    localparam int DIV_W    = BYTE_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [NUM_BYTES-1:0] wr_en,
    output logic [DIV_W-1:0]     div,
    output logic                 written
);

    // One byte lane per write enable.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (wr_en[g])
                lane_q <= wr_data;
        end
        assign div[g*BYTE_W +: BYTE_W] = lane_q;
    end

    // Flags that the divisor changed on the last edge.
    always_ff @(posedge clk) begin
        if (rst)
            written <= 1'b0;
        else
            written <= |wr_en;
    end

endmodule

// File: rtl/brg_counter.sv
module brg_counter #(
    parameter int DIV_W = brg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             reload,
    output logic             tick
);
    import brg_pkg::*;

    logic [DIV_W-1:0] count_q;
    logic             tick_q;
    cnt_act_e         act;
    logic [DIV_W-1:0] restart;

    assign restart = div - DIV_W'(1);

    always_comb begin
        act = pick_action(div == '0, reload, count_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            unique case (act)
                ACT_HALT: begin
                    count_q <= '0;
                    tick_q  <= 1'b0;
                end
                ACT_RELOAD: begin
                    count_q <= restart;
                    tick_q  <= 1'b0;
                end
                ACT_FIRE: begin
                    count_q <= restart;
                    tick_q  <= 1'b1;
                end
                default: begin
                    count_q <= count_q - DIV_W'(1);
                    tick_q  <= 1'b0;
                end
            endcase
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/brg_tick_gen.sv
module brg_tick_gen #(
    parameter int BYTE_W = brg_pkg::BYTE_W,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_lo,
    input  logic              wr_hi,
    output logic              tick,
    output logic [DIV_W-1:0]  div_q
);

    logic [1:0]       wr_en;
    logic [DIV_W-1:0] div;
    logic             written;

    assign wr_en = {wr_hi, wr_lo};

    brg_div_latch #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (2)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .div     (div),
        .written (written)
    );

    brg_counter #(
        .DIV_W (DIV_W)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .div    (div),
        .reload (written),
        .tick   (tick)
    );

    assign div_q = div;

endmodule

// File: rtl/brg_tick_gen_chk.sv
module brg_tick_gen_chk #(
    parameter int BYTE_W = brg_pkg::BYTE_W,
    localparam int DIV_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] wr_data,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic              tick,
    input logic [DIV_W-1:0]  div_q
);

    // Spacing monitor: cycles since the last strobe, valid only once
    // a strobe has been seen with no write around it.
    logic [DIV_W:0] gap;
    logic           seen;
    logic           wr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
            wr_d <= 1'b0;
        end else begin
            wr_d <= wr_lo | wr_hi;
            if (tick)
                gap <= (DIV_W+1)'(1);
            else if (gap != '1)
                gap <= gap + (DIV_W+1)'(1);
            if (wr_lo | wr_hi | wr_d)
                seen <= 1'b0;
            else if (tick)
                seen <= 1'b1;
        end
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!tick && div_q == '0));

    // R2 and R7
    a_r2_low_write: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (div_q[BYTE_W-1:0] == $past(wr_data)
                               && div_q[DIV_W-1:BYTE_W] == $past(div_q[DIV_W-1:BYTE_W])));

    a_r7_high_write: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (div_q[DIV_W-1:BYTE_W] == $past(wr_data)
                               && div_q[BYTE_W-1:0] == $past(div_q[BYTE_W-1:0])));

    // R3
    a_r3_even_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && seen) |-> (gap == {1'b0, div_q}));

    // R4
    a_r4_one_wide: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q > DIV_W'(1) && $stable(div_q)) |=> !tick);

    // R5
    a_r5_zero_silent: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0 && $stable(div_q)) |-> !tick);

endmodule

bind brg_tick_gen brg_tick_gen_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .tick    (tick),
    .div_q   (div_q)
);

// File: tb/test_brg_tick_gen.sv
module test_brg_tick_gen;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 16;
    localparam int LIMIT  = 70000;
    localparam int WATCH  = 190000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [BYTE_W-1:0] wr_data = '0;
    logic              wr_lo = 1'b0;
    logic              wr_hi = 1'b0;
    logic              tick;
    logic [DIV_W-1:0]  div_q;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    brg_tick_gen #(.BYTE_W(BYTE_W)) i_brg_tick_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_data),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .tick    (tick),
        .div_q   (div_q)
    );

    // Expected values from the requirements.
    function automatic int exp_gap(input int n);
        return n;
    endfunction

    function automatic int exp_first(input int n);
        return n + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_lo   = !hi;
        wr_hi   = hi;
        @(negedge clk);
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
    endtask

    task automatic wr_both(input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_lo   = 1'b1;
        wr_hi   = 1'b1;
        @(negedge clk);
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
    endtask

    // Cycles until the next strobe, counted from the current negedge.
    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < LIMIT);
    endtask

    // Load lo then hi; check first strobe and two spacings.
    task automatic run_div(input int n, input int reps);
        int got;
        wr_byte(1'b0, n[7:0]);
        wr_byte(1'b1, n[15:8]);
        check("R2 readback", int'(div_q), n);
        next_tick(got);
        check("R6 first strobe after load", got, exp_first(n));
        for (int i = 0; i < reps; i++) begin
            next_tick(got);
            check("R3 strobe spacing", got, exp_gap(n));
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCH && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCH);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int got;
        int cnt;
        int n;
        void'($urandom(32'd5150));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(tick), 0);
        check("R1 divisor in reset", int'(div_q), 0);
        rst = 1'b0;
        cnt = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
        check("R1 R5 silent after reset", cnt, 0);

        // R3 directed small divisors
        run_div(1, 4);
        run_div(2, 4);
        // R4: for divisor 2 the cycle after a strobe is low
        @(negedge clk);
        check("R4 one cycle wide", int'(tick), 0);
        run_div(3, 3);
        run_div(4, 3);

        // R7: writing low byte keeps high byte
        wr_byte(1'b1, 8'hA5);
        wr_byte(1'b0, 8'h3C);
        check("R7 high kept on low write", int'(div_q), 16'hA53C);
        wr_byte(1'b1, 8'h00);
        check("R7 low kept on high write", int'(div_q), 16'h003C);
        wr_both(8'h00);
        check("R7 both strobes", int'(div_q), 0);

        // R5: zero divisor, no strobe
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
        check("R5 zero divisor silent", cnt, 0);

        // Random divisors
        for (int k = 0; k < 10; k++) begin
            n = 1 + int'($urandom_range(59));
            run_div(n, 2);
        end

        // R6: mid-period reload from 40 down to 5
        run_div(40, 1);
        repeat (10) @(negedge clk);
        wr_byte(1'b0, 8'd5);
        wr_byte(1'b1, 8'd0);
        next_tick(got);
        check("R6 mid-period reload", got, exp_first(5));
        next_tick(got);
        check("R6 new rate spacing", got, exp_gap(5));

        // R1: reset during operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset tick", int'(tick), 0);
        check("R1 mid-run reset divisor", int'(div_q), 0);
        rst = 1'b0;

        // R3 largest divisor
        run_div(65535, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule